// File: doc/BRIEF.md
# Carrier Interrupt Aggregation Controller

This block gathers the interrupt requests of four plug-in module slots, two request lines per slot, into a single active-high host interrupt. Each slot has an 8-bit control register. It enables each of the slot's two request lines and chooses edge or level behaviour for each one. A 16-bit status word holds one pending flag per request line and one timeout flag per slot. The timeout flags are set by an external strobe.

Software reaches the registers through a simple 16-bit write port with a combinational read path, using word offsets. A level-mode line holds the host interrupt high for as long as its pending flag stays set. An edge-mode line produces a single-cycle host pulse when its pending flag rises. Software does not clear a pending flag itself. Writing a one to a pending bit sends a one-cycle clear strobe to the owning module, and the module then drops its request.

Top module: `irq_carrier_ctl`

## Requirements
- R1: After a synchronous reset, all control registers and the status word read zero, `host_irq` is low and `mod_clr` is zero.
- R2: Control registers sit at offsets 0x02, 0x04, 0x06 and 0x08 for slots 0 to 3. A write stores bits 7:0, and a read returns them with bits 15:8 at zero. Offset 0x00 (revision), offset 0x0A (reset word) and every reserved offset read zero, and writes to them change nothing.
- R3: Request line i of slot n drives status bit 2n+i and `mod_req`/`mod_clr` bit 2n+i. While control bit 6+i is set, that pending bit follows the request and shows the request sampled one cycle earlier.
- R4: While the enable bit of a line is clear, changes on its request are ignored and its pending bit holds its value.
- R5: A line whose control bit 4+i is clear is in level mode. When a level-mode pending bit changes, the host level is recomputed as the OR of all pending bits that are in level mode.
- R6: When the pending bit of an edge-mode line rises, `host_irq` rises for exactly one cycle. A falling edge-mode bit produces no pulse.
- R7: A cycle in which no level-mode pending bit changes leaves the host level unchanged. This holds even when a control write changes the mode of a line that is already pending.
- R8: Writing to status offset 0x0C with bit 2n+i set raises `mod_clr[2n+i]` for exactly the next cycle. The write does not change the pending bit itself.
- R9: A strobe on `tmo_strobe[n]` sets status bit 12+n. Writing a one to that bit clears it, and a strobe arriving in the same cycle as the clearing write wins.
- R10: Status bits 11:8 always read zero, and writing ones to them has no effect. Control bits 3:0 are stored and read back, and they do not affect the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| mod_req | input | 8 | Module request lines, bit 2n+i = slot n line i |
| mod_clr | output | 8 | One-cycle clear strobes to the modules |
| tmo_strobe | input | 4 | Timeout event per slot |
| host_irq | output | 1 | Host interrupt, active high |

## Verification
The bench first drives a single level-mode line, which shows that the host level tracks one pending flag. It then overlaps two level lines and removes them one at a time, which separates a true OR from a last-writer result. An edge-mode line is raised and lowered to show that only its rise produces a pulse exactly one cycle wide. Mode and enable changes made while a line is pending show that the host level moves only on a level-mode status change and that a disabled line keeps its flag. Clearing writes and timeout strobes, including a clear and a strobe in the same cycle, separate the strobe path from direct clearing of the status.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
// Shared constants for the carrier interrupt controller.
// Assumes four slots of two lines each and a 16-bit status word whose
// layout (pending, error, timeout) is fixed by the register interface.
package irqc_pkg;
    localparam int SLOTS    = 4;
    localparam int LINES    = 2;
    localparam int REQS     = SLOTS * LINES;
    localparam int DW       = 16;
    localparam int AW       = 8;
    localparam int CW       = 8;
    localparam int ERR_BITS = DW - REQS - SLOTS;

    // control register field positions
    localparam int CB_EDGE0 = 4;
    localparam int CB_EN0   = 6;

    // word offsets
    localparam logic [AW-1:0] OFS_REV   = 8'h00;
    localparam logic [AW-1:0] OFS_CTRL0 = 8'h02;
    localparam logic [AW-1:0] OFS_RST   = 8'h0A;
    localparam logic [AW-1:0] OFS_STAT  = 8'h0C;
endpackage

// File: rtl/irqc_ctrl_bank.sv
`timescale 1ns/1ps
// Per-slot control registers.
// Holds one CW-bit register per slot and exposes enable and edge-mode
// masks indexed by request line (slot*LINES + line).
// Assumes wr_sel is at most one-hot and already qualified by the write enable.
module irqc_ctrl_bank #(
    parameter int SLOTS    = 4,
    parameter int LINES    = 2,
    parameter int CW       = 8,
    parameter int CB_EDGE0 = 4,
    parameter int CB_EN0   = 6,
    localparam int REQS    = SLOTS * LINES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SLOTS-1:0]          wr_sel,
    input  logic [CW-1:0]             wdata,
    output logic [SLOTS-1:0][CW-1:0]  ctrl_q,
    output logic [REQS-1:0]           en_mask,
    output logic [REQS-1:0]           edge_mask
);
    for (genvar n = 0; n < SLOTS; n++) begin : g_slot
        // store the control word of slot n
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_q[n] <= '0;
            else if (wr_sel[n])
                ctrl_q[n] <= wdata;
        end
        for (genvar i = 0; i < LINES; i++) begin : g_line
            assign en_mask[n*LINES+i]   = ctrl_q[n][CB_EN0+i];
            assign edge_mask[n*LINES+i] = ctrl_q[n][CB_EDGE0+i];
        end
    end
endmodule

// File: rtl/irqc_status.sv
`timescale 1ns/1ps
// Pending and timeout flags plus module clear strobes.
// Enabled lines copy their request each cycle, and disabled lines hold.
// A status write turns ones in the pending field into one-cycle clear
// strobes and clears timeout flags. A strobe in the same cycle wins.
module irqc_status #(
    parameter int REQS  = 8,
    parameter int SLOTS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REQS-1:0]  req,
    input  logic [REQS-1:0]  en_mask,
    input  logic             stat_we,
    input  logic [REQS-1:0]  wd_pend,
    input  logic [SLOTS-1:0] wd_tmo,
    input  logic [SLOTS-1:0] tmo_strobe,
    output logic [REQS-1:0]  pend_q,
    output logic [REQS-1:0]  pend_next,
    output logic [SLOTS-1:0] tmo_q,
    output logic [REQS-1:0]  mod_clr
);
    // next pending value: enabled lines follow the request
    assign pend_next = (req & en_mask) | (pend_q & ~en_mask);

    // pending, timeout and clear-strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            tmo_q   <= '0;
            mod_clr <= '0;
        end else begin
            pend_q  <= pend_next;
            tmo_q   <= (tmo_q & ~(stat_we ? wd_tmo : '0)) | tmo_strobe;
            mod_clr <= stat_we ? wd_pend : '0;
        end
    end
endmodule

// File: rtl/irqc_host_irq.sv
`timescale 1ns/1ps
// Host interrupt generation.
// The level part is recomputed only when a level-mode pending bit changes.
// The edge part is a one-cycle pulse on any edge-mode pending rise.
module irqc_host_irq #(
    parameter int REQS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [REQS-1:0] pend_q,
    input  logic [REQS-1:0] pend_next,
    input  logic [REQS-1:0] edge_mask,
    output logic            host_irq
);
    logic level_q;
    logic pulse_q;
    logic lvl_change;
    logic edge_rise;

    assign lvl_change = |((pend_next ^ pend_q) & ~edge_mask);
    assign edge_rise  = |(pend_next & ~pend_q & edge_mask);

    // level state and edge pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (lvl_change)
                level_q <= |(pend_next & ~edge_mask);
            pulse_q <= edge_rise;
        end
    end

    assign host_irq = level_q | pulse_q;
endmodule

// File: rtl/irq_carrier_ctl.sv
`timescale 1ns/1ps
// Carrier interrupt aggregation controller, top level.
// Decodes the register port, instantiates the control bank, the status
// logic and the host interrupt logic, and muxes read data.
// Assumes a single-cycle write strobe and a combinational read.
module irq_carrier_ctl
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_we,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [REQS-1:0] mod_req,
    output logic [REQS-1:0] mod_clr,
    input  logic [SLOTS-1:0] tmo_strobe,
    output logic            host_irq
);
    logic [SLOTS-1:0]          ctrl_sel;
    logic [SLOTS-1:0][CW-1:0]  ctrl_q;
    logic [REQS-1:0]           en_mask;
    logic [REQS-1:0]           edge_mask;
    logic [REQS-1:0]           pend_q;
    logic [REQS-1:0]           pend_next;
    logic [SLOTS-1:0]          tmo_q;
    logic [DW-1:0]             status_w;
    logic                      stat_we;
    logic                      unused_err_wd;

    for (genvar n = 0; n < SLOTS; n++) begin : g_dec
        assign ctrl_sel[n] = reg_we && (reg_addr == AW'(OFS_CTRL0 + 2*n));
    end
    assign stat_we       = reg_we && (reg_addr == OFS_STAT);
    assign unused_err_wd = ^reg_wdata[DW-SLOTS-1:REQS];
    assign status_w      = {tmo_q, {ERR_BITS{1'b0}}, pend_q};

    irqc_ctrl_bank #(
        .SLOTS(SLOTS), .LINES(LINES), .CW(CW),
        .CB_EDGE0(CB_EDGE0), .CB_EN0(CB_EN0)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_sel(ctrl_sel), .wdata(reg_wdata[CW-1:0]),
        .ctrl_q(ctrl_q), .en_mask(en_mask), .edge_mask(edge_mask)
    );

    irqc_status #(.REQS(REQS), .SLOTS(SLOTS)) u_stat (
        .clk(clk), .rst_n(rst_n), .req(mod_req), .en_mask(en_mask),
        .stat_we(stat_we), .wd_pend(reg_wdata[REQS-1:0]),
        .wd_tmo(reg_wdata[DW-1 -: SLOTS]), .tmo_strobe(tmo_strobe),
        .pend_q(pend_q), .pend_next(pend_next), .tmo_q(tmo_q), .mod_clr(mod_clr)
    );

    irqc_host_irq #(.REQS(REQS)) u_host (
        .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .pend_next(pend_next),
        .edge_mask(edge_mask), .host_irq(host_irq)
    );

    // read mux: status, control words, zero elsewhere
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_STAT)
            reg_rdata = status_w;
        for (int n = 0; n < SLOTS; n++) begin
            if (reg_addr == AW'(OFS_CTRL0 + 2*n))
                reg_rdata = {{(DW-CW){1'b0}}, ctrl_q[n]};
        end
    end
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
// Protocol checker for irq_carrier_ctl, attached by bind.
// Observes ports plus the status word and the enable mask.
module irqc_checker
    import irqc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    reg_addr,
    input logic             reg_we,
    input logic [REQS-1:0]  mod_clr,
    input logic [SLOTS-1:0] tmo_strobe,
    input logic             host_irq,
    input logic [DW-1:0]    status_w,
    input logic [REQS-1:0]  en_w
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!host_irq && mod_clr == '0));

    // R8
    clr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_clr != '0) |-> $past(reg_we && reg_addr == OFS_STAT));

    // R4
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((status_w[REQS-1:0] ^ $past(status_w[REQS-1:0])) & ~$past(en_w)) == '0));

    // R5
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> (status_w[REQS-1:0] != $past(status_w[REQS-1:0])));

    // R9
    tmo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_strobe != '0) |=> ((status_w[DW-1 -: SLOTS] & $past(tmo_strobe)) == $past(tmo_strobe)));
endmodule

bind irq_carrier_ctl irqc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .mod_clr(mod_clr), .tmo_strobe(tmo_strobe), .host_irq(host_irq),
    .status_w(status_w), .en_w(en_mask)
);

// File: tb/test_irq_carrier_ctl.sv
`timescale 1ns/1ps
// Scoreboard bench: scenario tasks push expected items, and a monitor
// compares them at the falling edge of the cycle they belong to.
module test_irq_carrier_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  mod_req = '0;
    logic [7:0]  mod_clr;
    logic [3:0]  tmo_strobe = '0;
    logic        host_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          at;
        int          kind;   // 0 host_irq, 1 reg_rdata, 2 mod_clr
        logic [15:0] val;
        string       tag;
    } item_t;
    item_t sb[$];

    localparam logic [7:0] ST = 8'h0C;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_carrier_ctl i_irq_carrier_ctl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mod_req(mod_req),
        .mod_clr(mod_clr), .tmo_strobe(tmo_strobe), .host_irq(host_irq)
    );

    // one cycle of stimulus, applied just after the rising edge
    task automatic step(input logic [7:0] a, input logic we, input logic [15:0] wd,
                        input logic [7:0] rq, input logic [3:0] tm);
        @(posedge clk); #1;
        reg_addr = a; reg_we = we; reg_wdata = wd; mod_req = rq; tmo_strobe = tm;
    endtask

    // expected value for the current cycle
    task automatic expect_item(input int k, input logic [15:0] v, input string tag);
        item_t it;
        it.at = cyc; it.kind = k; it.val = v; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: compare due items mid-cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            item_t it;
            logic [15:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = {15'd0, host_irq};
                1: act = reg_rdata;
                default: act = {8'd0, mod_clr};
            endcase
            checks++;
            if (act !== it.val) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.val);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        step(ST, 0, 0, 0, 0);
        expect_item(1, 16'h0000, "R1 status"); expect_item(0, 0, "R1 host"); expect_item(2, 0, "R1 clr");
        step(8'h02, 0, 0, 0, 0); expect_item(1, 0, "R1 ctrl");
        // R2 register map
        step(8'h02, 1, 16'hA5F3, 0, 0);
        step(8'h02, 0, 0, 0, 0); expect_item(1, 16'h00F3, "R2 ctrl readback");
        step(8'h04, 0, 0, 0, 0); expect_item(1, 16'h0000, "R2 other slot");
        step(8'h00, 1, 16'hFFFF, 0, 0);
        step(8'h00, 0, 0, 0, 0); expect_item(1, 0, "R2 revision");
        step(8'h0E, 1, 16'hFFFF, 0, 0);
        step(8'h0E, 0, 0, 0, 0); expect_item(1, 0, "R2 reserved");
        step(8'h0A, 0, 0, 0, 0); expect_item(1, 0, "R2 reset word");
        step(8'h02, 1, 16'h0000, 0, 0);
        step(8'h02, 0, 0, 0, 0); expect_item(1, 0, "R2 ctrl clear");
        // R4 disabled line ignored
        step(ST, 0, 0, 8'h01, 0);
        step(ST, 0, 0, 8'h01, 0); expect_item(1, 0, "R4 disabled"); expect_item(0, 0, "R4 host");
        // R3 / R5 single level line
        step(8'h02, 1, 16'h0040, 8'h01, 0);
        step(ST, 0, 0, 8'h01, 0);
        step(ST, 0, 0, 8'h01, 0); expect_item(1, 16'h0001, "R3 pending"); expect_item(0, 1, "R5 level high");
        step(ST, 0, 0, 8'h00, 0);
        step(ST, 0, 0, 8'h00, 0); expect_item(1, 0, "R3 drop"); expect_item(0, 0, "R5 level low");
        // R5 OR of two level lines
        step(8'h04, 1, 16'h0080, 0, 0);
        step(ST, 0, 0, 8'h09, 0);
        step(ST, 0, 0, 8'h09, 0); expect_item(1, 16'h0009, "R5 two pending"); expect_item(0, 1, "R5 or");
        step(ST, 0, 0, 8'h08, 0);
        step(ST, 0, 0, 8'h08, 0); expect_item(1, 16'h0008, "R5 one left"); expect_item(0, 1, "R5 still high");
        step(ST, 0, 0, 8'h00, 0);
        step(ST, 0, 0, 8'h00, 0); expect_item(0, 0, "R5 none left");
        // R6 edge line
        step(8'h06, 1, 16'h0050, 0, 0);
        step(ST, 0, 0, 8'h00, 0);
        step(ST, 0, 0, 8'h10, 0);
        step(ST, 0, 0, 8'h10, 0); expect_item(1, 16'h0010, "R6 pending"); expect_item(0, 1, "R6 pulse");
        step(ST, 0, 0, 8'h10, 0); expect_item(0, 0, "R6 pulse width"); expect_item(1, 16'h0010, "R6 held");
        step(ST, 0, 0, 8'h00, 0);
        step(ST, 0, 0, 8'h00, 0); expect_item(1, 0, "R6 fall"); expect_item(0, 0, "R6 no fall pulse");
        // R7 mode change on a pending line leaves host untouched
        step(ST, 0, 0, 8'h01, 0);
        step(ST, 0, 0, 8'h01, 0); expect_item(0, 1, "R7 setup");
        step(8'h02, 1, 16'h0050, 8'h01, 0);
        step(ST, 0, 0, 8'h01, 0);
        step(ST, 0, 0, 8'h01, 0); expect_item(0, 1, "R7 mode switch");
        step(ST, 0, 0, 8'h00, 0);
        step(ST, 0, 0, 8'h00, 0); expect_item(1, 0, "R7 edge fall"); expect_item(0, 1, "R7 untouched");
        step(ST, 0, 0, 8'h08, 0);
        step(ST, 0, 0, 8'h08, 0); expect_item(0, 1, "R7 recompute high");
        step(ST, 0, 0, 8'h00, 0);
        step(ST, 0, 0, 8'h00, 0); expect_item(0, 0, "R7 recompute low");
        // R4 disable while pending
        step(ST, 0, 0, 8'h08, 0);
        step(ST, 0, 0, 8'h08, 0); expect_item(1, 16'h0008, "R4 setup");
        step(8'h04, 1, 16'h0000, 8'h08, 0);
        step(ST, 0, 0, 8'h00, 0);
        step(ST, 0, 0, 8'h00, 0); expect_item(1, 16'h0008, "R4 hold"); expect_item(0, 1, "R4 host hold");
        step(8'h04, 1, 16'h0080, 8'h00, 0);
        step(ST, 0, 0, 8'h00, 0);
        step(ST, 0, 0, 8'h00, 0); expect_item(1, 0, "R4 reenable"); expect_item(0, 0, "R4 host low");
        // R8 clear strobe
        step(ST, 0, 0, 8'h08, 0);
        step(ST, 0, 0, 8'h08, 0); expect_item(1, 16'h0008, "R8 setup");
        step(ST, 1, 16'h0009, 8'h08, 0); expect_item(2, 0, "R8 before");
        step(ST, 0, 0, 8'h08, 0); expect_item(2, 16'h0009, "R8 strobe"); expect_item(1, 16'h0008, "R8 pending kept");
        step(ST, 0, 0, 8'h08, 0); expect_item(2, 0, "R8 strobe width");
        step(ST, 0, 0, 8'h00, 0);
        step(ST, 0, 0, 8'h00, 0); expect_item(1, 0, "R8 module dropped");
        // R9 timeout flags
        step(ST, 0, 0, 0, 4'b0101);
        step(ST, 0, 0, 0, 0); expect_item(1, 16'h5000, "R9 set");
        step(ST, 1, 16'h1000, 0, 0);
        step(ST, 0, 0, 0, 0); expect_item(1, 16'h4000, "R9 clear one");
        step(ST, 1, 16'h4000, 0, 4'b0100);
        step(ST, 0, 0, 0, 0); expect_item(1, 16'h4000, "R9 set wins");
        step(ST, 1, 16'h4000, 0, 0);
        step(ST, 0, 0, 0, 0); expect_item(1, 0, "R9 cleared");
        // R10 error bits and low control bits
        step(ST, 1, 16'h0F00, 0, 0);
        step(ST, 0, 0, 0, 0); expect_item(1, 0, "R10 err bits"); expect_item(2, 0, "R10 no strobe");
        step(8'h08, 1, 16'h000F, 0, 0);
        step(8'h08, 0, 0, 0, 0); expect_item(1, 16'h000F, "R10 low ctrl"); expect_item(0, 0, "R10 host");
        step(ST, 0, 0, 0, 0);
        step(ST, 0, 0, 0, 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule